// File: doc/BRIEF.md
# Multi-Cycle Phase-Skipping Processor Core

This block is a compact 32-bit processor core. It executes four instructions: register add, set-on-less-than against an immediate, word load and word store. Every instruction is broken into up to five phases: fetch, decode with operand read, execute, memory and register write. Exactly one phase runs in each clock. A controller state machine steps through the phases and spends no cycle on a phase that the current instruction has no use for. As a result, add, slti and sw each take four clocks, lw takes five, and an unrecognised word takes two.

The core holds its own program counter, a register file with two read ports and one write port, an ALU, and word-wide instruction and data memory arrays. Both arrays are loaded from outside before reset is released. The only inputs are the clock and an asynchronous active-low reset, which the core releases synchronously. The outputs are observation ports: the program counter, the current phase, and the register-file write strobe with its address and data.

Top module: `mcyc_core`

## Requirements
- R1: While reset is asserted and in the cycles after its release, dbg_pc is 0, dbg_state is 0 (fetch) and dbg_wr_en is 0. Once the reset synchronizer lets go, the first fetch comes from address 0.
- R2: Phase codes on dbg_state are: fetch 0, decode 1, execute 2, memory 3, write-back 4. A fetch latches the word at instruction index (PC/4) modulo the memory depth and adds 4 to the PC. The PC holds its value in every other phase, so dbg_pc shows the instruction's address during fetch and that address plus 4 afterwards.
- R3: An instruction word with bits [31:26]=0 and bits [5:0]=0x20 is an add. It writes rs+rt modulo 2^32 to rd (rs = bits [25:21], rt = bits [20:16], rd = bits [15:11]). Its phase sequence is fetch, decode, execute, write-back, which is four cycles with no memory phase.
- R4: Opcode 0x0A is slti. It writes 1 to rt when rs is less than the sign-extended bits [15:0] under a signed compare, and 0 otherwise. It takes the same four phases as add.
- R5: Opcode 0x23 is lw. It writes to rt the data word at byte address rs + sign-extended offset, indexed by address/4 modulo the data depth. It is the only instruction that uses all five phases.
- R6: Opcode 0x2B is sw. It stores rt to the data word at rs + sign-extended offset. It ends after the memory phase and raises no register write strobe.
- R7: Register 0 always reads as zero, and a write addressed to it leaves it at zero.
- R8: An instruction whose destination is also one of its sources reads the old values of its sources and writes the correct result.
- R9: A word with any other opcode, or with opcode 0 and bits [5:0] other than 0x20, runs fetch and decode only and then returns to fetch. It changes no register and no memory.
- R10: dbg_wr_en is 1 only in the write-back phase. During that cycle dbg_wr_addr and dbg_wr_data give the destination register and the value written, including a write addressed to register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_pc | output | 32 | Current program counter |
| dbg_state | output | 3 | Current phase code |
| dbg_wr_en | output | 1 | Register-file write strobe |
| dbg_wr_addr | output | 5 | Destination register of the write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The assertions check the phase-sequencing rules on every cycle: the memory phase is entered only for loads and stores, a store never reaches write-back, add and slti go from execute straight to write-back, and unknown words go back to fetch after decode. They also check that the PC and instruction register move only at fetch and that an operand read from register 0 is zero. Arithmetic results, signed-compare boundaries, modular add wrap, the store-then-load round trip through data memory and the case where a destination equals a source can only be shown by the bench's program. There, an instruction-level reference model predicts the phase, PC and write strobe of every cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NREGS  = 1 << REG_AW;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADD,
    OP_SLTI,
    OP_LOAD,
    OP_STORE
  } opkind_e;

  typedef struct packed {
    logic [5:0]  opc;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] low;
  } iword_t;

  function automatic opkind_e classify(input iword_t w);
    opkind_e k;
    unique case (w.opc)
      OPC_RTYPE: k = (w.low[5:0] == FN_ADD) ? OP_ADD : OP_NONE;
      OPC_SLTI:  k = OP_SLTI;
      OPC_LW:    k = OP_LOAD;
      OPC_SW:    k = OP_STORE;
      default:   k = OP_NONE;
    endcase
    return k;
  endfunction

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mc_ram.sv
module mc_ram #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] regs [NREGS];
  logic            wr_live;

  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  opkind_e         kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] sum_rr;
  logic [XLEN-1:0] sum_ri;
  logic            lt_signed;

  assign sum_rr    = opa + opb;
  assign sum_ri    = opa + imm;
  assign lt_signed = $signed(opa) < $signed(imm);

  always_comb begin
    unique case (kind)
      OP_ADD:            result = sum_rr;
      OP_SLTI:           result = {{(XLEN-1){1'b0}}, lt_signed};
      OP_LOAD, OP_STORE: result = sum_ri;
      default:           result = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opkind_e kind,
  output phase_e  phase,
  output logic    fetch_en,
  output logic    opnd_en,
  output logic    alu_en,
  output logic    mdr_en,
  output logic    dm_we,
  output logic    rf_we
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = (kind == OP_NONE) ? PH_FETCH : PH_EXEC;
      PH_EXEC:   phase_d = (kind == OP_LOAD || kind == OP_STORE) ? PH_MEM : PH_WB;
      PH_MEM:    phase_d = (kind == OP_LOAD) ? PH_WB : PH_FETCH;
      PH_WB:     phase_d = PH_FETCH;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign phase    = phase_q;
  assign fetch_en = (phase_q == PH_FETCH);
  assign opnd_en  = (phase_q == PH_DECODE);
  assign alu_en   = (phase_q == PH_EXEC);
  assign mdr_en   = (phase_q == PH_MEM) && (kind == OP_LOAD);
  assign dm_we    = (phase_q == PH_MEM) && (kind == OP_STORE);
  assign rf_we    = (phase_q == PH_WB);

  AST_MEM_ONLY_LDST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MEM) |-> (kind == OP_LOAD || kind == OP_STORE)); // R5
  AST_LOAD_REACHES_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MEM && kind == OP_LOAD) |=> (phase_q == PH_WB)); // R5
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WB) |-> (kind != OP_STORE)); // R6
  AST_ALU_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && (kind == OP_ADD || kind == OP_SLTI)) |=> (phase_q == PH_WB)); // R3
  AST_NOP_BACK_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECODE && kind == OP_NONE) |=> (phase_q == PH_FETCH)); // R9
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] dbg_pc,
  output logic [2:0]  dbg_state,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_addr,
  output logic [31:0] dbg_wr_data
);
  localparam int unsigned IA_W = $clog2(IMEM_WORDS);
  localparam int unsigned DA_W = $clog2(DMEM_WORDS);

  logic            core_rst_n;
  phase_e          phase;
  logic            fetch_en, opnd_en, alu_en, mdr_en, dm_we, rf_we;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
  logic [XLEN-1:0] imem_word, dmem_word, rs_val, rt_val, alu_res, imm_ext, wb_data;
  iword_t          iw;
  opkind_e         kind;
  logic [REG_AW-1:0] wb_addr;

  mc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(core_rst_n)
  );

  assign iw      = iword_t'(ir_q);
  assign kind    = classify(iw);
  assign imm_ext = sext16(iw.low);

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .kind(kind), .phase(phase),
    .fetch_en(fetch_en), .opnd_en(opnd_en), .alu_en(alu_en),
    .mdr_en(mdr_en), .dm_we(dm_we), .rf_we(rf_we)
  );

  mc_ram #(.WORDS(IMEM_WORDS), .WIDTH(XLEN)) u_imem (
    .clk(clk), .we(1'b0), .waddr('0), .wdata('0),
    .raddr(pc_q[IA_W+1:2]), .rdata(imem_word)
  );

  mc_ram #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(alu_q[DA_W+1:2]), .wdata(b_q),
    .raddr(alu_q[DA_W+1:2]), .rdata(dmem_word)
  );

  mc_regfile u_rf (
    .clk(clk), .rst_n(core_rst_n),
    .ra1(iw.rs), .ra2(iw.rt), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(wb_addr), .wd(wb_data)
  );

  mc_alu u_alu (
    .kind(kind), .opa(a_q), .opb(b_q), .imm(imm_ext), .result(alu_res)
  );

  // program counter and instruction register advance together at fetch
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else if (fetch_en) begin
      pc_q <= pc_q + XLEN'(4);
      ir_q <= imem_word;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (opnd_en) begin
      a_q <= rs_val;
      b_q <= rt_val;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  alu_q <= '0;
    else if (alu_en)  alu_q <= alu_res;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  mdr_q <= '0;
    else if (mdr_en)  mdr_q <= dmem_word;
  end

  assign wb_addr = (kind == OP_ADD) ? iw.low[15:11] : iw.rt;
  assign wb_data = (kind == OP_LOAD) ? mdr_q : alu_q;

  assign dbg_pc      = pc_q;
  assign dbg_state   = phase;
  assign dbg_wr_en   = rf_we;
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

  AST_PC_STEP_AT_FETCH: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == PH_FETCH) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_PC_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase != PH_FETCH) |=> $stable(pc_q)); // R2
  AST_IR_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase != PH_FETCH) |=> $stable(ir_q)); // R8
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == PH_DECODE && iw.rs == '0) |=> (a_q == '0)); // R7
  AST_STROBE_IN_WB: assert property (@(posedge clk) disable iff (!core_rst_n)
    dbg_wr_en |-> (dbg_state == 3'd4)); // R10
endmodule

// File: tb/sim_mcyc_core.sv
`timescale 1ns/1ps
module sim_mcyc_core;
  logic        clk;
  logic        rst_n;
  logic [31:0] dbg_pc;
  logic [2:0]  dbg_state;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  logic [31:0] mim [64];
  logic [31:0] mdm [64];
  logic [31:0] mrf [32];
  logic [31:0] mpc;

  int          q_st [$];
  logic [31:0] q_pc [$];
  bit          q_we [$];
  int          q_wa [$];
  logic [31:0] q_wd [$];
  string       q_tag [$];

  mcyc_core u0 (
    .clk(clk), .rst_n(rst_n), .dbg_pc(dbg_pc), .dbg_state(dbg_state),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int opc, int rs, int rt, int imm);
    return {6'(opc), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] rv(int r);
    return (r == 0) ? 32'd0 : mrf[r];
  endfunction

  task automatic push(int st, logic [31:0] pc, bit we, int wa, logic [31:0] wd, string tag);
    q_st.push_back(st); q_pc.push_back(pc); q_we.push_back(we);
    q_wa.push_back(wa); q_wd.push_back(wd); q_tag.push_back(tag);
  endtask

  // behavioural model: executes a whole instruction, queues its expected cycles
  task automatic model_issue();
    logic [31:0] w, ix, ea, res, npc;
    int op, rs, rt, rd, fn;
    string tag;
    w  = mim[(mpc >> 2) & 63];
    op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
    rd = int'(w[15:11]); fn = int'(w[5:0]);
    ix = {{16{w[15]}}, w[15:0]};
    push(0, mpc, 0, 0, 0, "R2 fetch");
    npc = mpc + 4;
    mpc = npc;
    if (op == 0 && fn == 32) begin
      res = rv(rs) + rv(rt);
      if (rs == 0 || rt == 0 || rd == 0) tag = "R7 add";
      else if (rd == rs || rd == rt)     tag = "R8 add";
      else                               tag = "R3 add";
      push(1, npc, 0, 0, 0, tag); push(2, npc, 0, 0, 0, tag);
      push(4, npc, 1, rd, res, {"R10 ", tag});
      if (rd != 0) mrf[rd] = res;
    end else if (op == 10) begin
      res = ($signed(rv(rs)) < $signed(ix)) ? 32'd1 : 32'd0;
      tag = (rs == 0) ? "R7 slti" : "R4 slti";
      push(1, npc, 0, 0, 0, tag); push(2, npc, 0, 0, 0, tag);
      push(4, npc, 1, rt, res, {"R10 ", tag});
      if (rt != 0) mrf[rt] = res;
    end else if (op == 35) begin
      ea  = rv(rs) + ix;
      res = mdm[(ea >> 2) & 63];
      push(1, npc, 0, 0, 0, "R5 lw"); push(2, npc, 0, 0, 0, "R5 lw");
      push(3, npc, 0, 0, 0, "R5 lw");
      push(4, npc, 1, rt, res, "R10 R5 lw");
      if (rt != 0) mrf[rt] = res;
    end else if (op == 43) begin
      ea = rv(rs) + ix;
      mdm[(ea >> 2) & 63] = rv(rt);
      push(1, npc, 0, 0, 0, "R6 sw"); push(2, npc, 0, 0, 0, "R6 sw");
      push(3, npc, 0, 0, 0, "R6 sw");
    end else begin
      push(1, npc, 0, 0, 0, "R9 nop");
    end
  endtask

  task automatic check_cycle();
    int st; logic [31:0] pc; bit we; int wa; logic [31:0] wd; string tag;
    bit bad;
    if (q_st.size() == 0) model_issue();
    st = q_st.pop_front(); pc = q_pc.pop_front(); we = q_we.pop_front();
    wa = q_wa.pop_front(); wd = q_wd.pop_front(); tag = q_tag.pop_front();
    nchk++;
    bad = (int'(dbg_state) != st) || (dbg_pc != pc) || (dbg_wr_en != we);
    if (we) bad = bad || (int'(dbg_wr_addr) != wa) || (dbg_wr_data != wd);
    if (bad) begin
      nfail++;
      $display("FAIL %s: actual st=%0d pc=%h we=%0b wa=%0d wd=%h expected st=%0d pc=%h we=%0b wa=%0d wd=%h",
               tag, dbg_state, dbg_pc, dbg_wr_en, dbg_wr_addr, dbg_wr_data, st, pc, we, wa, wd);
    end
  endtask

  task automatic check_reset();
    nchk++;
    if (dbg_pc != 0 || dbg_state != 0 || dbg_wr_en != 0) begin
      nfail++;
      $display("FAIL R1 reset: actual pc=%h st=%0d we=%0b expected pc=0 st=0 we=0",
               dbg_pc, dbg_state, dbg_wr_en);
    end
  endtask

  initial begin
    rst_n = 0;
    for (int i = 0; i < 64; i++) begin
      mim[i] = 32'd0;
      mdm[i] = 32'(i) * 32'h0101_0101;
    end
    for (int i = 0; i < 32; i++) mrf[i] = 32'd0;
    mdm[0] = 32'h7FFF_FFFF; mdm[1] = 32'h0000_0001;
    mdm[2] = 32'hFFFF_FFFF; mdm[4] = 32'd32;
    mim[0]  = enc_i(35, 0, 1, 0);          // lw r1,0(r0)
    mim[1]  = enc_i(35, 0, 2, 4);          // lw r2,4(r0)
    mim[2]  = enc_r(1, 2, 3, 32);          // add r3 = 0x80000000
    mim[3]  = enc_i(35, 0, 4, 8);          // lw r4 = -1
    mim[4]  = enc_r(4, 2, 5, 32);          // add r5 wraps to 0
    mim[5]  = enc_i(10, 3, 6, 0);          // slti most negative < 0
    mim[6]  = enc_i(10, 1, 7, 16'hFFFF);   // slti max positive < -1
    mim[7]  = enc_i(10, 4, 8, 0);          // slti -1 < 0
    mim[8]  = enc_i(10, 2, 9, 1);          // slti equal boundary
    mim[9]  = enc_r(1, 1, 1, 32);          // add r1 = r1 + r1
    mim[10] = enc_i(43, 0, 1, 12);         // sw r1,12(r0)
    mim[11] = enc_i(35, 0, 10, 12);        // lw r10,12(r0)
    mim[12] = enc_i(35, 0, 11, 16);        // lw r11 = 32
    mim[13] = enc_i(43, 11, 3, 16'hFFFC);  // sw r3,-4(r11)
    mim[14] = enc_i(35, 0, 12, 28);        // lw r12,28(r0)
    mim[15] = enc_r(1, 1, 0, 32);          // add r0 (ignored)
    mim[16] = enc_r(0, 2, 13, 32);         // add r13 = r0 + r2
    mim[17] = 32'hFC00_0000;               // unknown opcode
    mim[18] = enc_r(1, 1, 2, 34);          // unknown funct, targets r2
    mim[19] = enc_r(2, 0, 14, 32);         // add r14 = r2
    mim[20] = enc_i(10, 0, 15, 5);         // slti r15 = r0 < 5
    for (int i = 0; i < 64; i++) begin
      u0.u_imem.mem[i] = mim[i];
      u0.u_dmem.mem[i] = mdm[i];
    end
    mpc = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); check_reset();
    rst_n = 1;
    @(negedge clk); check_reset();
    @(posedge clk);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      check_cycle();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule